// File: doc/BRIEF.md
# Triplicated Fast-to-Slow Event Synchronizer

This block moves a single-bit event from a fast sender clock into a slower receiver clock. The transfer uses triple modular redundancy. Each of three independent lanes catches a short sender pulse in a holding register and keeps it until the lane's own receiver-side synchronizer has seen it. A return path then releases the holding register so the next event can be caught. On the receiver side, each lane's held level passes through a chain of flip-flops.

The three lanes sample asynchronously, so they can report the same event one receiver cycle apart. For this reason each lane has its own registered voter. The voter combines the lane's current and previous synchronized values with the current values of the two other lanes. A one-cycle skew between lanes therefore never splits or drops a vote. A rising-edge detector follows each voter and turns every event into a single receiver-cycle pulse on each of the three outputs. A single lane stuck high or stuck low does not change that result.

Top module: `tmr_event_sync`

## Requirements
- R1: A lane's holding register, once set by a one-sender-cycle pulse on its input copy, stays set until that lane's return path reports the level back; it is then cleared.
- R2: With all three lanes healthy and per-lane input skews of zero to two sender cycles, each event produces exactly one pulse on every bit of `pulse_out`.
- R3: Every output pulse lasts exactly one receiver cycle.
- R4: The first output pulse of an event appears within SYNC_STAGES+5 receiver cycles of the first input copy being driven.
- R5: With one input copy held at 0, each event on the other two copies still produces exactly one pulse on every output bit.
- R6: With one input copy held at 1, no pulse appears while the fault sits idle, and each event on the other two copies produces exactly one pulse on every output bit.
- R7: While `rst` is high and in the cycle after it, `pulse_out` is 0; after reset with no input activity it stays 0.
- R8: An event seen on only one lane produces no output pulse; a voter rises only after at least two lanes reported a 1 in the cycle before.
- R9: Events separated by at least 24 receiver cycles each give their own single pulse on every output bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_snd | input | 1 | Fast sender-domain clock |
| clk_rcv | input | 1 | Slow receiver-domain clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| evt_in | input | 3 | Three redundant copies of the sender event, one bit per lane, each a pulse of one sender cycle |
| pulse_out | output | 3 | Voted receiver-domain pulses, one per lane |

## Verification
On every cycle, the assertions watch that a holding register is never dropped before its lane's return path confirms the level. They also check that output pulses never last two cycles, that outputs stay quiet across reset, and that a voter only rises after two lanes had reported a 1. Only the bench scenarios can show the end-to-end claims. These are: exactly one pulse per event under lane skew, tolerance of a stuck-low or stuck-high copy, rejection of a single-lane event, and the latency bound.

// File: rtl/tmr_sync_pkg.sv
package tmr_sync_pkg;

    localparam int LANES = 3;

    typedef logic [LANES-1:0] lane_vec_t;

    // Observation of one lane in the receiver domain
    typedef struct packed {
        logic cur;   // last synchronizer stage
        logic prev;  // the same stage one receiver cycle earlier
    } lane_obs_t;

    // Own lane counts as a 1 if it shows one now or showed one last cycle,
    // so a lane that is early by one cycle still pairs with a late peer.
    function automatic logic vote3(lane_obs_t own, logic peer_a, logic peer_b);
        logic own_seen;
        own_seen = own.cur | own.prev;
        return (own_seen & peer_a) | (own_seen & peer_b) | (peer_a & peer_b);
    endfunction

endpackage

// File: rtl/evt_hold.sv
module evt_hold #(
    parameter int ACK_STAGES = 2
) (
    input  logic clk_snd,
    input  logic rst,
    input  logic evt,
    input  logic done_rcv,
    output logic held,
    output logic ack
);
    localparam int ASTG = (ACK_STAGES < 2) ? 2 : ACK_STAGES;

    logic [ASTG-1:0] ack_sr;

    // Return path: receiver-domain level brought into the sender clock
    always_ff @(posedge clk_snd) begin
        if (rst) ack_sr <= '0;
        else     ack_sr <= {ack_sr[ASTG-2:0], done_rcv};
    end

    assign ack = ack_sr[ASTG-1];

    // Set on the event, cleared once the receiver side confirmed it
    always_ff @(posedge clk_snd) begin
        if (rst)      held <= 1'b0;
        else if (evt) held <= 1'b1;
        else if (ack) held <= 1'b0;
    end

endmodule

// File: rtl/lane_sync.sv
module lane_sync
    import tmr_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk_rcv,
    input  logic      rst,
    input  logic      held,
    output lane_obs_t obs
);
    localparam int NSTG = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    logic [NSTG-1:0] chain;
    logic            last_q;

    always_ff @(posedge clk_rcv) begin
        if (rst) begin
            chain  <= '0;
            last_q <= 1'b0;
        end else begin
            chain  <= {chain[NSTG-2:0], held};
            last_q <= chain[NSTG-1];
        end
    end

    assign obs.cur  = chain[NSTG-1];
    assign obs.prev = last_q;

endmodule

// File: rtl/lane_voter.sv
module lane_voter
    import tmr_sync_pkg::*;
(
    input  logic      clk_rcv,
    input  logic      rst,
    input  lane_obs_t own,
    input  logic      peer_a,
    input  logic      peer_b,
    output logic      vote,
    output logic      pulse
);
    logic vote_d;

    always_ff @(posedge clk_rcv) begin
        if (rst) begin
            vote   <= 1'b0;
            vote_d <= 1'b0;
        end else begin
            vote   <= vote3(own, peer_a, peer_b);
            vote_d <= vote;
        end
    end

    assign pulse = vote & ~vote_d;

endmodule

// File: rtl/tmr_event_sync.sv
module tmr_event_sync
    import tmr_sync_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ACK_STAGES  = 2
) (
    input  logic            clk_snd,
    input  logic            clk_rcv,
    input  logic            rst,
    input  logic [LANES-1:0] evt_in,
    output logic [LANES-1:0] pulse_out
);
    lane_vec_t held_q;
    lane_vec_t ack_q;
    lane_vec_t obs_cur;
    lane_vec_t obs_prev;
    lane_vec_t vote_q;
    lane_obs_t obs [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int PA = (g + 1) % LANES;
        localparam int PB = (g + 2) % LANES;

        evt_hold #(.ACK_STAGES(ACK_STAGES)) u_hold (
            .clk_snd  (clk_snd),
            .rst      (rst),
            .evt      (evt_in[g]),
            .done_rcv (obs[g].cur),
            .held     (held_q[g]),
            .ack      (ack_q[g])
        );

        lane_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk_rcv (clk_rcv),
            .rst     (rst),
            .held    (held_q[g]),
            .obs     (obs[g])
        );

        assign obs_cur[g]  = obs[g].cur;
        assign obs_prev[g] = obs[g].prev;

        lane_voter u_vote (
            .clk_rcv (clk_rcv),
            .rst     (rst),
            .own     (obs[g]),
            .peer_a  (obs[PA].cur),
            .peer_b  (obs[PB].cur),
            .vote    (vote_q[g]),
            .pulse   (pulse_out[g])
        );
    end

endmodule

// File: rtl/tmr_event_sync_chk.sv
module tmr_event_sync_chk
    import tmr_sync_pkg::*;
(
    input logic      clk_snd,
    input logic      clk_rcv,
    input logic      rst,
    input lane_vec_t pulse_out,
    input lane_vec_t held_q,
    input lane_vec_t ack_q,
    input lane_vec_t obs_cur,
    input lane_vec_t obs_prev,
    input lane_vec_t vote_q
);
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_snd) disable iff (rst) (held_q[g] && !ack_q[g]) |=> held_q[g]); // R1
        AST_PULSE_SINGLE: assert property (@(posedge clk_rcv) disable iff (rst) pulse_out[g] |=> !pulse_out[g]); // R3
        AST_VOTE_NEEDS_PAIR: assert property (@(posedge clk_rcv) disable iff (rst) $rose(vote_q[g]) |-> ($countones($past(obs_cur | obs_prev)) >= 2)); // R8
    end

    AST_RESET_QUIET: assert property (@(posedge clk_rcv) rst |=> (pulse_out == '0)); // R7

endmodule

bind tmr_event_sync tmr_event_sync_chk u_chk (
    .clk_snd   (clk_snd),
    .clk_rcv   (clk_rcv),
    .rst       (rst),
    .pulse_out (pulse_out),
    .held_q    (held_q),
    .ack_q     (ack_q),
    .obs_cur   (obs_cur),
    .obs_prev  (obs_prev),
    .vote_q    (vote_q)
);

// File: tb/tmr_event_sync_test.sv
module tmr_event_sync_test;

    localparam int STG = 2;
    localparam int LAT_MAX = STG + 5;
    localparam int WIN = 24;

    logic       clk_snd = 1'b0;
    logic       clk_rcv = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] evt_in = '0;
    logic [2:0] pulse_out;

    int checks = 0;
    int fails = 0;
    int rcyc = 0;
    int pcnt [3] = '{0, 0, 0};
    int plast [3] = '{0, 0, 0};
    logic [2:0] stuck_hi = '0;

    tmr_event_sync #(.SYNC_STAGES(STG), .ACK_STAGES(2)) uut (
        .clk_snd   (clk_snd),
        .clk_rcv   (clk_rcv),
        .rst       (rst),
        .evt_in    (evt_in),
        .pulse_out (pulse_out)
    );

    always #1.0 clk_snd = ~clk_snd;   // 500 MHz sender
    always #2.5 clk_rcv = ~clk_rcv;   // 200 MHz receiver

    always @(posedge clk_rcv) rcyc <= rcyc + 1;

    always @(negedge clk_rcv) begin
        for (int i = 0; i < 3; i++) begin
            if (pulse_out[i] === 1'b1) begin
                pcnt[i]  = pcnt[i] + 1;
                plast[i] = rcyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_rcv(input int n);
        repeat (n) @(negedge clk_rcv);
    endtask

    // Drive one event: lanes in 'act' pulse after their own delay in sender cycles
    task automatic fire(input int d0, input int d1, input int d2,
                        input logic [2:0] act, input int exp_pulses,
                        input string req);
        int base [3];
        int start;
        int dl [3];
        dl[0] = d0; dl[1] = d1; dl[2] = d2;
        for (int i = 0; i < 3; i++) base[i] = pcnt[i];
        @(negedge clk_snd);
        start = rcyc;
        for (int t = 0; t < 3; t++) begin
            logic [2:0] v;
            v = stuck_hi;
            for (int i = 0; i < 3; i++)
                if (act[i] && dl[i] == t) v[i] = 1'b1;
            evt_in = v;
            @(negedge clk_snd);
        end
        evt_in = stuck_hi;
        wait_rcv(WIN);
        for (int i = 0; i < 3; i++) begin
            chk(pcnt[i] - base[i] == exp_pulses, req, $sformatf("pulse count lane %0d", i),
                pcnt[i] - base[i], exp_pulses);
            if (exp_pulses > 0)
                chk(plast[i] - start <= LAT_MAX, "R4", $sformatf("latency lane %0d", i),
                    plast[i] - start, LAT_MAX);
        end
    endtask

    task automatic t_reset();
        wait_rcv(2);
        chk(pulse_out == 3'b000, "R7", "outputs during reset", pulse_out, 0);
        @(negedge clk_rcv);
        rst = 1'b0;
        wait_rcv(10);
        chk(pulse_out == 3'b000, "R7", "outputs idle after reset", pulse_out, 0);
        chk(pcnt[0] + pcnt[1] + pcnt[2] == 0, "R7", "pulses after reset", pcnt[0] + pcnt[1] + pcnt[2], 0);
    endtask

    task automatic t_aligned();
        fire(0, 0, 0, 3'b111, 1, "R2");
    endtask

    task automatic t_skewed();
        fire(0, 2, 1, 3'b111, 1, "R2");
        fire(2, 0, 1, 3'b111, 1, "R2");
        fire(1, 2, 0, 3'b111, 1, "R2");
    endtask

    task automatic t_burst();
        for (int k = 0; k < 4; k++) fire(k % 3, (k + 1) % 3, 0, 3'b111, 1, "R9");
    endtask

    task automatic t_lone();
        fire(0, 0, 0, 3'b001, 0, "R8");
        fire(1, 0, 0, 3'b100, 0, "R8");
    endtask

    task automatic t_stuck_low();
        fire(0, 1, 2, 3'b101, 1, "R5");
        fire(2, 0, 1, 3'b110, 1, "R5");
    endtask

    task automatic t_stuck_high();
        int base;
        base = pcnt[0] + pcnt[1] + pcnt[2];
        stuck_hi = 3'b010;
        @(negedge clk_snd);
        evt_in = stuck_hi;
        wait_rcv(WIN);
        chk(pcnt[0] + pcnt[1] + pcnt[2] == base, "R6", "pulses from idle stuck lane",
            pcnt[0] + pcnt[1] + pcnt[2] - base, 0);
        fire(0, 0, 2, 3'b101, 1, "R6");
        fire(2, 0, 0, 3'b101, 1, "R6");
        stuck_hi = 3'b000;
        @(negedge clk_snd);
        evt_in = '0;
        wait_rcv(WIN);
        fire(0, 1, 0, 3'b111, 1, "R2");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1000000;
        chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        finish_run();
    end

    initial begin
        t_reset();
        t_aligned();
        t_skewed();
        t_lone();
        t_stuck_low();
        t_stuck_high();
        t_burst();
        finish_run();
    end

endmodule